// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block is the shift datapath of a processor ALU. It is purely combinational. It takes a 32-bit source value and an R-format function code, and it returns the shifted or rotated result. The amount comes from one of two places: the 5-bit amount field carried in the instruction, or the low bits of a register value. Bit 2 of the function code picks between them.

A separate rotate select turns the same function codes into rotations. With the select high, a left code rotates left and a right code rotates right, so bits that leave one end come back in at the other.

Internally the block has three parts:

- a decoder that turns the function code and rotate select into a control word;
- a log-depth barrel that only ever moves bits toward the least significant end;
- a pair of bit-order reversers that fold left operations onto that right-moving barrel.

The barrel has one stage per amount bit. Each stage chooses its incoming bits from zeros, copies of the original top bit, or the bits it pushes out.

Top module: `shift_unit`

## Requirements
- R1: Function code 6'b000000 with the rotate select low shifts left by the instruction amount. Vacated low-order bits are zero.
- R2: Function code 6'b000010 with the rotate select low shifts right by the instruction amount. Vacated high-order bits are zero.
- R3: Function code 6'b000011 with the rotate select low shifts right by the instruction amount. Vacated high-order bits copy the source's most significant bit.
- R4: Codes 6'b000100, 6'b000110 and 6'b000111 behave as left, logical right and arithmetic right. Their amount is bits [4:0] of the register amount, so values of 32 or more wrap modulo 32.
- R5: The amount input not chosen by the code has no effect. Instruction-amount forms ignore the register amount, and register-amount forms ignore the instruction amount.
- R6: With the rotate select high, codes 6'b000000 and 6'b000100 rotate left, and codes 6'b000010 and 6'b000110 rotate right. Each uses the amount source of its code.
- R7: With the rotate select high, the arithmetic codes 6'b000011 and 6'b000111 rotate right exactly like the logical right codes, with no sign replication.
- R8: An effective amount of zero returns the source value unchanged for every supported operation.
- R9: Any function code outside the six listed gives a zero result, whatever the rotate select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | 6 | R-format function code selecting operation and amount source |
| rot_sel | input | 1 | High turns the shift into a rotation in the same direction |
| src_val | input | 32 | Value to be shifted or rotated |
| imm_amt | input | 5 | Shift amount taken from the instruction |
| reg_amt | input | 32 | Shift amount taken from a register; only the low 5 bits count |
| shift_out | output | 32 | Shifted or rotated result |

## Verification
The bench builds the block with its default width of 32, so the amount is 5 bits wide. Sweeping all 32 amounts therefore drives every one of the 32 on/off combinations of the five barrel stages, including the widest 16-bit stage.

At this width, register amounts of 32 and above are easy to reach, which exercises the wrap rule. Random sources with the top bit forced set make the sign fill and the rotate paths visible. Random values on the unused amount input show whether it leaks into the result.

// File: rtl/shift_pkg.sv
package shift_pkg;

    // Function codes recognised by the unit
    localparam logic [5:0] FN_SLL  = 6'b000000;
    localparam logic [5:0] FN_SRL  = 6'b000010;
    localparam logic [5:0] FN_SRA  = 6'b000011;
    localparam logic [5:0] FN_SLLV = 6'b000100;
    localparam logic [5:0] FN_SRLV = 6'b000110;
    localparam logic [5:0] FN_SRAV = 6'b000111;

    // What enters a barrel stage from the top end
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  valid;     // code is one of the six supported
        logic  go_left;   // fold through the bit reversers
        logic  from_reg;  // amount from register instead of instruction
        fill_e fill;      // bits entering at the top of each stage
    } shift_ctrl_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
(
    input  logic [5:0]  fn_code,
    input  logic        rot_sel,
    output shift_ctrl_t ctrl
);

    always_comb begin
        ctrl = '{valid: 1'b0, go_left: 1'b0, from_reg: 1'b0, fill: FILL_ZERO};
        unique case (fn_code)
            FN_SLL, FN_SLLV: begin
                ctrl.valid   = 1'b1;
                ctrl.go_left = 1'b1;
                ctrl.fill    = rot_sel ? FILL_WRAP : FILL_ZERO;
            end
            FN_SRL, FN_SRLV: begin
                ctrl.valid = 1'b1;
                ctrl.fill  = rot_sel ? FILL_WRAP : FILL_ZERO;
            end
            FN_SRA, FN_SRAV: begin
                ctrl.valid = 1'b1;
                ctrl.fill  = rot_sel ? FILL_WRAP : FILL_SIGN;
            end
            default: ctrl.valid = 1'b0;
        endcase
        // bit 2 separates register-amount forms from instruction-amount forms
        ctrl.from_reg = fn_code[2];
    end

endmodule

// File: rtl/shift_reverse.sv
module shift_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
    import shift_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  fill_e         fill,
    input  logic          sign_bit,
    output logic [W-1:0]  dout
);

    // stage k moves the data by 2**k toward bit 0 when amt[k] is set
    logic [W-1:0] stg [AW+1];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [SH-1:0] top_bits;

        always_comb begin
            unique case (fill)
                FILL_WRAP: top_bits = stg[k][SH-1:0];
                FILL_SIGN: top_bits = {SH{sign_bit}};
                default:   top_bits = '0;
            endcase
        end

        assign stg[k+1] = amt[k] ? {top_bits, stg[k][W-1:SH]} : stg[k];
    end

    assign dout = stg[AW];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [5:0]        fn_code,
    input  logic              rot_sel,
    input  logic [DATA_W-1:0] src_val,
    input  logic [AMT_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    output logic [DATA_W-1:0] shift_out
);

    shift_ctrl_t       ctrl;
    logic [AMT_W-1:0]  amt_eff;
    logic [DATA_W-1:0] src_rev, bar_in, bar_out, out_rev;

    shift_decode i_decode (
        .fn_code (fn_code),
        .rot_sel (rot_sel),
        .ctrl    (ctrl)
    );

    // only the low bits of the register amount matter: wrap modulo DATA_W
    assign amt_eff = ctrl.from_reg ? reg_amt[AMT_W-1:0] : imm_amt;

    shift_reverse #(.W(DATA_W)) i_rev_in (
        .din  (src_val),
        .dout (src_rev)
    );

    assign bar_in = ctrl.go_left ? src_rev : src_val;

    shift_barrel #(.W(DATA_W), .AW(AMT_W)) i_barrel (
        .din      (bar_in),
        .amt      (amt_eff),
        .fill     (ctrl.fill),
        .sign_bit (src_val[DATA_W-1]),
        .dout     (bar_out)
    );

    shift_reverse #(.W(DATA_W)) i_rev_out (
        .din  (bar_out),
        .dout (out_rev)
    );

    always_comb begin
        if (!ctrl.valid)       shift_out = '0;
        else if (ctrl.go_left) shift_out = out_rev;
        else                   shift_out = bar_out;
    end

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input logic [5:0]        fn_code,
    input logic              rot_sel,
    input logic [DATA_W-1:0] src_val,
    input logic [AMT_W-1:0]  imm_amt,
    input logic [DATA_W-1:0] reg_amt,
    input logic [DATA_W-1:0] shift_out
);

    logic             known, ok_code, is_left, is_arith;
    logic [AMT_W-1:0] n;
    logic [DATA_W-1:0] ones;

    always_comb begin
        known    = !$isunknown({fn_code, rot_sel, src_val, imm_amt, reg_amt});
        ok_code  = (fn_code == FN_SLL) || (fn_code == FN_SRL) || (fn_code == FN_SRA) ||
                   (fn_code == FN_SLLV) || (fn_code == FN_SRLV) || (fn_code == FN_SRAV);
        is_left  = (fn_code == FN_SLL) || (fn_code == FN_SLLV);
        is_arith = (fn_code == FN_SRA) || (fn_code == FN_SRAV);
        n        = fn_code[2] ? reg_amt[AMT_W-1:0] : imm_amt;
        ones     = '1;
    end

    always_comb begin
        if (known) begin
            // R1 and the left half of R4
            if (ok_code && !rot_sel && is_left)
                a_r1_left_low_zero: assert ((shift_out & ~(ones << n)) == '0)
                    else $error("left shift left nonzero low bits");
            // R2 and the logical-right half of R4
            if (ok_code && !rot_sel && !is_left && !is_arith)
                a_r2_right_high_zero: assert ((shift_out & ~(ones >> n)) == '0)
                    else $error("logical right shift left nonzero high bits");
            // R3: the sign survives
            if (ok_code && !rot_sel && is_arith)
                a_r3_sign_kept: assert (shift_out[DATA_W-1] == src_val[DATA_W-1])
                    else $error("arithmetic right shift changed the sign");
            // R6/R7: a rotation neither loses nor creates set bits
            if (ok_code && rot_sel)
                a_r6_rot_ones_kept: assert ($countones(shift_out) == $countones(src_val))
                    else $error("rotation changed the count of set bits");
            // R8
            if (ok_code && n == '0)
                a_r8_zero_amt_pass: assert (shift_out == src_val)
                    else $error("zero amount altered the value");
            // R9
            if (!ok_code)
                a_r9_bad_code_zero: assert (shift_out == '0)
                    else $error("unsupported code gave nonzero result");
        end
    end

endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) i_chk (
    .fn_code   (fn_code),
    .rot_sel   (rot_sel),
    .src_val   (src_val),
    .imm_amt   (imm_amt),
    .reg_amt   (reg_amt),
    .shift_out (shift_out)
);

// File: tb/test_shift_unit.sv
module test_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  fn_code = '0;
    logic        rot_sel = 1'b0;
    logic [31:0] src_val = '0;
    logic [4:0]  imm_amt = '0;
    logic [31:0] reg_amt = '0;
    logic [31:0] shift_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    shift_unit i_shift_unit (
        .fn_code   (fn_code),
        .rot_sel   (rot_sel),
        .src_val   (src_val),
        .imm_amt   (imm_amt),
        .reg_amt   (reg_amt),
        .shift_out (shift_out)
    );

    // reference result, written straight from the requirements
    function automatic logic [31:0] ref_val(logic [5:0] f, logic r, logic [31:0] x,
                                            logic [4:0] ia, logic [31:0] ra);
        int a;
        a = f[2] ? int'(ra[4:0]) : int'(ia);
        case (f)
            6'b000000, 6'b000100:
                return r ? ((x << a) | (x >> (32 - a))) : (x << a);
            6'b000010, 6'b000110:
                return r ? ((x >> a) | (x << (32 - a))) : (x >> a);
            6'b000011, 6'b000111:
                return r ? ((x >> a) | (x << (32 - a))) : 32'($signed(x) >>> a);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: fn=%b rot=%b src=%h imm=%0d reg=%h got %h expected %h",
                     tag, fn_code, rot_sel, src_val, imm_amt, reg_amt, act, exp);
        end
    endtask

    task automatic apply(logic [5:0] f, logic r, logic [31:0] x, logic [4:0] ia,
                         logic [31:0] ra);
        @(posedge clk);
        fn_code = f; rot_sel = r; src_val = x; imm_amt = ia; reg_amt = ra;
        @(negedge clk);
    endtask

    function automatic string tag_of(logic [5:0] f, logic r);
        if (r) return (f[1:0] == 2'b11) ? "R7" : "R6";
        case (f)
            6'b000000: return "R1";
            6'b000010: return "R2";
            6'b000011: return "R3";
            default:   return "R4";
        endcase
    endfunction

    initial begin
        logic [5:0] codes [6];
        logic [31:0] x, ra;
        logic [4:0] ia;
        codes = '{6'b000000, 6'b000010, 6'b000011, 6'b000100, 6'b000110, 6'b000111};
        void'($urandom(32'h5eed_0042));

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset state", shift_out, 32'h0);

        // every supported operation, every amount, random data with sign set too
        for (int c = 0; c < 6; c++) begin
            for (int r = 0; r < 2; r++) begin
                for (int a = 0; a < 32; a++) begin
                    for (int k = 0; k < 3; k++) begin
                        x = $urandom();
                        if (k == 0) x[31] = 1'b1;
                        ia = codes[c][2] ? 5'($urandom()) : 5'(a);   // R5 noise
                        ra = codes[c][2] ? {$urandom_range(0, 7) == 0 ? 27'($urandom()) : 27'h0, 5'(a)}
                                         : $urandom();
                        apply(codes[c], r[0], x, ia, ra);
                        check(tag_of(codes[c], r[0]), shift_out,
                              ref_val(codes[c], r[0], x, ia, ra));
                    end
                end
            end
        end

        // R4: register amounts at and beyond the width wrap
        apply(6'b000100, 1'b0, 32'h8000_0001, 5'd0, 32'd37);
        check("R4 wrap 37", shift_out, 32'h0000_0020);
        apply(6'b000110, 1'b0, 32'hF000_000F, 5'd3, 32'd32);
        check("R4 wrap 32", shift_out, 32'hF000_000F);
        apply(6'b000111, 1'b0, 32'h8000_0000, 5'd0, 32'hFFFF_FFFF);
        check("R4 wrap 31", shift_out, 32'hFFFF_FFFF);

        // R5: instruction form ignores a large register amount
        apply(6'b000010, 1'b0, 32'hDEAD_BEEF, 5'd4, 32'hFFFF_FFFF);
        check("R5 reg ignored", shift_out, 32'h0DEA_DBEE);
        apply(6'b000110, 1'b0, 32'hDEAD_BEEF, 5'd31, 32'd4);
        check("R5 imm ignored", shift_out, 32'h0DEA_DBEE);

        // R3 and R7 corner values
        apply(6'b000011, 1'b0, 32'h8000_0000, 5'd31, 32'h0);
        check("R3 full sign fill", shift_out, 32'hFFFF_FFFF);
        apply(6'b000011, 1'b1, 32'h8000_0001, 5'd1, 32'h0);
        check("R7 rotate arith code", shift_out, 32'hC000_0000);
        apply(6'b000000, 1'b1, 32'h8000_0001, 5'd4, 32'h0);
        check("R6 rotate left", shift_out, 32'h0000_0018);

        // R8: zero amount on each code
        for (int c = 0; c < 6; c++) begin
            apply(codes[c], c[0], 32'hA5C3_0F81, 5'd0, 32'h20);
            check("R8 zero amount", shift_out, 32'hA5C3_0F81);
        end

        // R9: unsupported codes give zero whatever the rotate select
        foreach (codes[c]) begin end
        for (int b = 0; b < 4; b++) begin
            logic [5:0] bad;
            bad = (b == 0) ? 6'b000001 : (b == 1) ? 6'b000101 :
                  (b == 2) ? 6'b100000 : 6'b111111;
            apply(bad, b[0], 32'hFFFF_FFFF, 5'd3, 32'd3);
            check("R9 bad code", shift_out, 32'h0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

endmodule